// File: doc/BRIEF.md
# Digital RF Pulse Slot Generator

This block turns one pair of control words per carrier period into a one-bit pulse train for a switching power amplifier. Each carrier period is cut into eight equal time slots. A 3-bit width code sets how many adjacent slots are driven high. A three-level phase code puts the pulse one slot early, centred or one slot late. At most three of the eight slots are ever high, so the pulse always covers less than half the period.

Control words come in with a valid strobe, one accepted strobe per carrier period. The block shapes each period into an 8-bit slot pattern. It packs two patterns into a 16-bit word for an external 16:1 serializer. With 200 MHz words this gives a 3.2 Gb/s slot stream, which carries a 400 MHz carrier. The modulators that produce the control words, the serializer and the amplifier are outside the block.

Top module: `rf_pulse_slot_gen`

## Requirements
- R1: Width codes 0, 1, 2 and 3 give exactly that many high slots, and the high slots of a period are adjacent.
- R2: Width codes 4 to 7 give three high slots. `width_sat` is high in any cycle where `ctrl_valid` is high and the width code is 4 or more, and low in every other cycle.
- R3: Slots are numbered 0 (sent first) to 7. A centred pulse of width w starts at slot 4 - ceil(w/2). Phase code 2'b00 centres the pulse, 2'b11 (-1) moves it one slot earlier, 2'b01 (+1) moves it one slot later, and the unused code 2'b10 is treated as centred.
- R4: Slot 0 and slot 7 of every period stay low, so a pulse never crosses a period boundary.
- R5: Width code 0 gives an all-zero period, whatever the phase code.
- R6: Slot k of a period sits at bit 7-k of that period's byte. The earlier of the two periods fills `slot_word[15:8]`, so bit 15 is sent first.
- R7: Every two accepted periods produce one word. `word_valid` pulses for one cycle, in the cycle after the clock edge that accepted the second period. Cycles with `ctrl_valid` low do not advance or disturb the pairing.
- R8: While `rst_n` is low, `slot_word` is zero and `word_valid` is low. A half-assembled pair is dropped, so the first period accepted after reset starts a new word.
- R9: `slot_word` keeps its last value until the next word completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ctrl_valid | input | 1 | Control words for one carrier period are present |
| width_code | input | 3 | Pulse width code |
| phase_code | input | 2 | Pulse position code, two's complement -1/0/+1 |
| slot_word | output | 16 | Two periods of slot bits, bit 15 sent first |
| word_valid | output | 1 | One-cycle strobe when `slot_word` has just been updated |
| width_sat | output | 1 | Width code was clipped to three slots this cycle |

## Verification
The bench sweeps every width against every phase code, including the unused phase code and the clipped widths 4 to 7. A wrong centring formula or a reversed phase sign shows up as a byte shifted by one bit. Swapping the period order or the bit order within a byte mirrors the word, and the asymmetric pairs in the table expose that. Idle gaps between the two periods of a pair, a reset in the middle of a pair, and idle cycles after a word catch a packer that counts cycles instead of strobes, keeps a stale half-pair, or clears the word early.

// File: rtl/rf_pulse_pkg.sv
package rf_pulse_pkg;

  typedef enum logic [1:0] {
    PH_CENTRE = 2'b00,
    PH_LATE   = 2'b01,
    PH_RSVD   = 2'b10,
    PH_EARLY  = 2'b11
  } phase_e;

endpackage

// File: rtl/rf_period_shaper.sv
module rf_period_shaper
  import rf_pulse_pkg::*;
#(
  parameter int SLOTS    = 8,
  parameter int WBITS    = 3,
  parameter int MAX_HIGH = 3
) (
  input  logic [WBITS-1:0] width_code,
  input  logic [1:0]       phase_code,
  output logic [SLOTS-1:0] period_bits,
  output logic             clipped
);

  localparam int IW = $clog2(SLOTS) + 2;

  logic [IW-1:0] eff_w;
  logic [IW-1:0] start_c;
  phase_e        ph;

  always_comb begin
    ph      = phase_e'(phase_code);
    clipped = (width_code > WBITS'(MAX_HIGH));
    eff_w   = clipped ? IW'(MAX_HIGH) : IW'(width_code);
    start_c = IW'(SLOTS / 2) - ((eff_w + IW'(1)) >> 1);
    case (ph)
      PH_EARLY: start_c = start_c - IW'(1);
      PH_LATE:  start_c = start_c + IW'(1);
      default:  start_c = start_c;
    endcase
  end

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    localparam logic [IW-1:0] KPOS = IW'(k);
    assign period_bits[SLOTS-1-k] = (eff_w != '0) &&
                                    (KPOS >= start_c) &&
                                    (KPOS < start_c + eff_w);
  end

endmodule

// File: rtl/rf_pair_packer.sv
module rf_pair_packer #(
  parameter int SLOTS   = 8,
  parameter int PERIODS = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [SLOTS-1:0]         in_bits,
  output logic [SLOTS*PERIODS-1:0] word,
  output logic                     word_valid
);

  localparam int CW   = (PERIODS > 2) ? $clog2(PERIODS) : 1;
  localparam int HOLD = SLOTS * (PERIODS - 1);

  logic [CW-1:0]              cnt_q, cnt_d;
  logic [HOLD-1:0]            held_q, held_d;
  logic [SLOTS*PERIODS-1:0]   word_q, word_d;
  logic                       wv_q, wv_d;
  logic                       last_slot;

  always_comb begin
    last_slot = (cnt_q == CW'(PERIODS - 1));
    cnt_d     = cnt_q;
    held_d    = held_q;
    word_d    = word_q;
    wv_d      = 1'b0;
    if (in_valid) begin
      if (last_slot) begin
        word_d = {held_q, in_bits};
        wv_d   = 1'b1;
        cnt_d  = '0;
      end else begin
        if (PERIODS > 2) held_d = HOLD'({held_q, in_bits});
        else             held_d = HOLD'(in_bits);
        cnt_d  = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      held_q <= '0;
      word_q <= '0;
      wv_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      held_q <= held_d;
      word_q <= word_d;
      wv_q   <= wv_d;
    end
  end

  assign word       = word_q;
  assign word_valid = wv_q;

  // R7
  wv_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(in_valid));

  // R7
  wv_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  // R9
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> $stable(word));

endmodule

// File: rtl/rf_pulse_slot_gen.sv
module rf_pulse_slot_gen #(
  parameter int SLOTS    = 8,
  parameter int PERIODS  = 2,
  parameter int WBITS    = 3,
  parameter int MAX_HIGH = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ctrl_valid,
  input  logic [WBITS-1:0]         width_code,
  input  logic [1:0]               phase_code,
  output logic [SLOTS*PERIODS-1:0] slot_word,
  output logic                     word_valid,
  output logic                     width_sat
);

  logic [SLOTS-1:0] period_bits;
  logic             clipped;

  rf_period_shaper #(
    .SLOTS(SLOTS), .WBITS(WBITS), .MAX_HIGH(MAX_HIGH)
  ) u_shaper (
    .width_code (width_code),
    .phase_code (phase_code),
    .period_bits(period_bits),
    .clipped    (clipped)
  );

  rf_pair_packer #(
    .SLOTS(SLOTS), .PERIODS(PERIODS)
  ) u_packer (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (ctrl_valid),
    .in_bits   (period_bits),
    .word      (slot_word),
    .word_valid(word_valid)
  );

  assign width_sat = ctrl_valid & clipped;

  // R2
  high_slot_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_valid |-> ($countones(period_bits) <= MAX_HIGH));

  // R4
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_valid |-> (!period_bits[SLOTS-1] && !period_bits[0]));

  // R5
  zero_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_valid && width_code == '0) |-> (period_bits == '0));

endmodule

// File: tb/rf_pulse_slot_gen_tb.sv
module rf_pulse_slot_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctrl_valid;
  logic [2:0]  width_code;
  logic [1:0]  phase_code;
  logic [15:0] slot_word;
  logic        word_valid;
  logic        width_sat;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rf_pulse_slot_gen u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_valid(ctrl_valid),
    .width_code(width_code), .phase_code(phase_code),
    .slot_word(slot_word), .word_valid(word_valid), .width_sat(width_sat)
  );

  // {w0, p0, w1, p1, expected word}
  localparam int NV = 11;
  localparam logic [25:0] VEC [NV] = '{
    {3'd1, 2'b00, 3'd1, 2'b11, 16'h1020},
    {3'd1, 2'b01, 3'd2, 2'b00, 16'h0818},
    {3'd2, 2'b11, 3'd2, 2'b01, 16'h300C},
    {3'd3, 2'b00, 3'd3, 2'b11, 16'h3870},
    {3'd3, 2'b01, 3'd0, 2'b01, 16'h1C00},
    {3'd0, 2'b11, 3'd7, 2'b00, 16'h0038},
    {3'd4, 2'b01, 3'd5, 2'b11, 16'h1C70},
    {3'd2, 2'b10, 3'd6, 2'b10, 16'h1838},
    {3'd1, 2'b10, 3'd3, 2'b10, 16'h1038},
    {3'd0, 2'b00, 3'd0, 2'b10, 16'h0000},
    {3'd2, 2'b00, 3'd1, 2'b01, 16'h1808}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] w, input logic [1:0] p);
    @(negedge clk);
    ctrl_valid = 1'b1; width_code = w; phase_code = p;
    #1;
    check("R2 width_sat", 32'(width_sat), 32'(w >= 3'd4));
  endtask

  task automatic idle();
    @(negedge clk);
    ctrl_valid = 1'b0; width_code = 3'd0; phase_code = 2'b00;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ctrl_valid = 1'b0; width_code = 3'd0; phase_code = 2'b00;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 reset word", 32'(slot_word), 32'h0);
    check("R8 reset valid", 32'(word_valid), 32'h0);
    check("R2 sat idle", 32'(width_sat), 32'h0);
    rst_n = 1'b1;

    // R1 R3 R5 R6 R7 table walk
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][25:23], VEC[i][22:21]);
      drive(VEC[i][20:18], VEC[i][17:16]);
      check("R7 no strobe mid pair", 32'(word_valid), 32'h0);
      idle();
      check("R7 strobe", 32'(word_valid), 32'h1);
      check("R1 R3 R6 word", 32'(slot_word), 32'(VEC[i][15:0]));
    end

    // R9 word holds over idle cycles
    repeat (3) begin
      idle();
      check("R9 hold", 32'(slot_word), 32'h1808);
      check("R7 strobe once", 32'(word_valid), 32'h0);
    end

    // R7 gaps between the two periods do not break pairing
    drive(3'd3, 2'b11);
    repeat (3) begin
      idle();
      check("R7 gap no strobe", 32'(word_valid), 32'h0);
      check("R9 gap hold", 32'(slot_word), 32'h1808);
    end
    drive(3'd1, 2'b01);
    idle();
    check("R7 gap strobe", 32'(word_valid), 32'h1);
    check("R7 gap word", 32'(slot_word), 32'h7008);

    // R8 reset drops a half pair
    drive(3'd2, 2'b00);
    idle();
    rst_n = 1'b0;
    #1;
    check("R8 async clear", 32'(slot_word), 32'h0);
    check("R8 async valid", 32'(word_valid), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(3'd1, 2'b11);
    drive(3'd3, 2'b01);
    idle();
    check("R8 fresh strobe", 32'(word_valid), 32'h1);
    check("R8 fresh word", 32'(slot_word), 32'h201C);
    idle();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule